// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host read and write PHY registers over the two-wire MDC/MDIO management bus. The host has a small word-addressed register file. It loads the PHY number and register number into an address register. For writes it also loads a 16-bit value into a write-data register. It then sets either the read-request or the write-request bit of the control register.

The controller then generates one clause-22 management frame. MDC comes from a divider of the system clock. A status bit reads 1 while the frame is running. A read result is kept in a dedicated read-data register.

The host polls the status bit until it returns to 0. It then fetches the result if the access was a read. A frame lasts 64 MDC periods. With a divider chosen for a 2.5 MHz MDC, an access ends well inside the couple of milliseconds that a polling host allows.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every readable register (offsets 0 to 4) reads 0, MDC is low and the MDIO output enable is low.
- R2: The address register (offset 1) keeps the PHY number in bits [12:8] and the register number in bits [4:0]. All other bits read as 0.
- R3: A write request (control offset 0, bit 2 set, bit 3 clear) sends 32 ones, then 01, then opcode 01, then the 5-bit PHY number, the 5-bit register number, then turnaround 10, then the 16 write-data bits. All fields go out MSB first.
- R4: A read request (control bit 3 set, bit 2 clear) sends the same header with opcode 10. It then drops the MDIO output enable for the two turnaround bit times and the 16 data bit times. The 16 sampled bits appear in bits [15:0] of the read-data register (offset 4).
- R5: Status bit 0 (offset 3) reads 1 from the cycle after an accepted request until the frame completes, then reads 0. The request bit clears by itself at completion.
- R6: A control write that arrives while status bit 0 is 1 is ignored. No second frame is sent and the running frame keeps the PHY and register numbers it started with.
- R7: A control write with both request bits set, or with neither set, starts no frame and leaves status at 0.
- R8: MDC runs only during a frame. Each MDC half period lasts HALF_DIV system clocks. The driven MDIO level changes only while MDC is low, and read data is sampled at the rising MDC edge.
- R9: A write access leaves the read-data register unchanged. That register is updated only when a read completes.
- R10: The write-data register (offset 2) keeps bits [15:0] and reads 0 in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset of the register being accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered, one cycle after reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data as seen on the wire |

## Verification
Some properties are checked on every cycle:
- MDIO holds still while MDC is high.
- The output enable is never high unless a request is pending.
- The two request bits are never set together.
- The busy flag rises only after a control write and falls right after completion.
- The read-data register moves only when a read request retires.

The rest can only be shown by the bench scenarios, using a PHY model that captures each frame:
- the exact bit order of each frame;
- the release of the line during turnaround;
- the values returned by reads, including read-after-write;
- the MDC period;
- the fact that requests made while busy, or ambiguous ones, never produce an extra frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Clause-22 frame geometry
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;  // first turnaround bit index
  localparam int DATA_FIRST = 48;  // first data bit index
  localparam int DATA_W     = 16;
  localparam int FLD_W      = 5;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
  localparam logic [1:0] TA_READ  = 2'b11;

  // Register offsets (word index)
  localparam int RA_CTRL  = 0;
  localparam int RA_ADDR  = 1;
  localparam int RA_WDATA = 2;
  localparam int RA_STAT  = 3;
  localparam int RA_RDATA = 4;

  // Control bits
  localparam int CTL_RD_BIT = 3;
  localparam int CTL_WR_BIT = 2;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_rd,
  input  logic [FLD_W-1:0]  phy,
  input  logic [FLD_W-1:0]  regn,
  input  logic [DATA_W-1:0] wval,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_word
);
  localparam int IW = $clog2(FRAME_BITS) + 1;

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic [IW-1:0]         idx_nx;
  logic                  rd_q;

  assign idx_nx = idx + 1'b1;
  assign mdio_o = sh[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          idx     <= '0;
          rd_q    <= op_rd;
          mdio_oe <= 1'b1;
          sh <= {{PRE_BITS{1'b1}}, SOF_BITS,
                 op_rd ? OP_READ : OP_WRITE, phy, regn,
                 op_rd ? TA_READ : TA_WRITE,
                 op_rd ? {DATA_W{1'b1}} : wval};
        end
      end else begin
        if (rise && rd_q && (idx >= IW'(DATA_FIRST)))
          rd_word <= {rd_word[DATA_W-2:0], mdio_i};
        if (fall) begin
          if (idx == IW'(FRAME_BITS - 1)) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx     <= idx_nx;
            sh      <= {sh[FRAME_BITS-2:0], 1'b1};
            mdio_oe <= !(rd_q && (idx_nx >= IW'(TA_FIRST)));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              launch_o,
  output logic              op_rd_o,
  output logic [FLD_W-1:0]  phy_o,
  output logic [FLD_W-1:0]  regn_o,
  output logic [DATA_W-1:0] wval_o,
  output logic              busy_o
);
  logic              rd_req_q, wr_req_q;
  logic [DATA_W-1:0] rd_val_q;
  logic [DW-1:0]     rd_mux;
  logic              ctl_ok;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DW-1:DATA_W];
  assign busy_o  = rd_req_q | wr_req_q;
  assign op_rd_o = rd_req_q;
  assign ctl_ok  = wdata[CTL_RD_BIT] ^ wdata[CTL_WR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      launch_o <= 1'b0;
      phy_o    <= '0;
      regn_o   <= '0;
      wval_o   <= '0;
      rd_val_q <= '0;
      rdata    <= '0;
    end else begin
      launch_o <= 1'b0;
      rdata    <= rd_mux;
      if (we) begin
        if (addr == AW'(RA_ADDR)) begin
          phy_o  <= wdata[12:8];
          regn_o <= wdata[4:0];
        end
        if (addr == AW'(RA_WDATA))
          wval_o <= wdata[DATA_W-1:0];
        if (addr == AW'(RA_CTRL) && !busy_o && ctl_ok) begin
          rd_req_q <= wdata[CTL_RD_BIT];
          wr_req_q <= wdata[CTL_WR_BIT];
          launch_o <= 1'b1;
        end
      end
      if (done_i) begin
        if (rd_req_q) rd_val_q <= rd_word_i;
        rd_req_q <= 1'b0;
        wr_req_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(RA_CTRL)) begin
      rd_mux[CTL_RD_BIT] = rd_req_q;
      rd_mux[CTL_WR_BIT] = wr_req_q;
    end
    if (addr == AW'(RA_ADDR)) begin
      rd_mux[12:8] = phy_o;
      rd_mux[4:0]  = regn_o;
    end
    if (addr == AW'(RA_WDATA)) rd_mux[DATA_W-1:0] = wval_o;
    if (addr == AW'(RA_STAT))  rd_mux[0] = busy_o;
    if (addr == AW'(RA_RDATA)) rd_mux[DATA_W-1:0] = rd_val_q;
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(we && addr == AW'(RA_CTRL)));
  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !busy_o);
  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_q && wr_req_q));
  // R9
  rdval_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_val_q) |-> $fell(rd_req_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int DW       = 32,
  parameter int AW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  logic              launch, op_rd, req_busy, frm_busy, done, rise, fall;
  logic [FLD_W-1:0]  phy, regn;
  logic [DATA_W-1:0] wval, rd_word;

  mdio_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done_i(done), .rd_word_i(rd_word),
    .launch_o(launch), .op_rd_o(op_rd), .phy_o(phy), .regn_o(regn),
    .wval_o(wval), .busy_o(req_busy)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .en(frm_busy), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .start(launch), .op_rd(op_rd), .phy(phy),
    .regn(regn), .wval(wval), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(frm_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rd_word(rd_word)
  );

  // R8
  mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R4
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> req_busy);
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0, phy_bit = 1'b1;

  always #4 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_ctrl #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_val(input logic [4:0] p, input logic [4:0] r);
    return ({11'd0, p} * 16'd2053) + ({11'd0, r} * 16'd331) + 16'h1234;
  endfunction

  // ---------------- PHY model and line monitors ----------------
  logic [63:0] cap = '0, last_frame = '0;
  int          rcnt = 0, frames = 0, cyc = 0, last_rise = 0;
  logic [1:0]  hdr_op = '0;
  logic [4:0]  hdr_phy = '0, hdr_reg = '0;
  logic [15:0] wmem [1024];
  bit          wvalid [1024];
  bit          oe_bad = 0, period_bad = 0, glitch_bad = 0;
  logic        prev_mdc = 1'b0, prev_o = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mdc && prev_mdc && (mdio_o !== prev_o)) glitch_bad = 1;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  always @(posedge mdc) begin
    logic [63:0] nxt;
    nxt = {cap[62:0], mdio_i};
    if (rcnt > 0 && (cyc - last_rise) != 2 * HALF) period_bad = 1;
    last_rise = cyc;
    if ((rcnt == 46 || rcnt == 47) && hdr_op == 2'b10 && mdio_oe) oe_bad = 1;
    if (rcnt == 45) begin
      hdr_op  = nxt[11:10];
      hdr_phy = nxt[9:5];
      hdr_reg = nxt[4:0];
    end
    if (rcnt == 63) begin
      last_frame = nxt;
      frames++;
      rcnt = 0;
      if (hdr_op == 2'b01) begin
        wmem[{hdr_phy, hdr_reg}]   = nxt[15:0];
        wvalid[{hdr_phy, hdr_reg}] = 1;
      end
    end else begin
      rcnt++;
    end
    cap = nxt;
  end

  always @(negedge mdc) begin
    logic [15:0] v;
    v = wvalid[{hdr_phy, hdr_reg}] ? wmem[{hdr_phy, hdr_reg}] : model_val(hdr_phy, hdr_reg);
    if (hdr_op == 2'b10 && rcnt >= 47 && rcnt <= 63) begin
      phy_en = 1'b1;
      if (rcnt == 47) phy_bit = 1'b0;
      else begin
        v = v >> (63 - rcnt);
        phy_bit = v[0];
      end
    end else begin
      phy_en = 1'b0;
    end
  end

  // ---------------- host access tasks ----------------
  logic [15:0] shadow [1024];
  bit          shadow_v [1024];

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin
      rd(3'd3, s);
      n++;
    end while (s[0] && n < 5000);
  endtask

  function automatic logic [15:0] expect_rd(input logic [4:0] p, input logic [4:0] r);
    return shadow_v[{p, r}] ? shadow[{p, r}] : model_val(p, r);
  endfunction

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] s, rbefore;
    logic [63:0] exp;
    int f0;
    rd(3'd4, rbefore);
    wr(3'd1, {19'd0, p, 3'd0, r});
    wr(3'd2, {16'd0, d});
    f0 = frames;
    wr(3'd0, 32'h4);
    rd(3'd3, s);
    check(s == 32'd1, "R5 busy after write request", 64'(s), 64'd1);
    wait_idle();
    check(frames == f0 + 1, "R3 one frame per write", 64'(frames), 64'(f0 + 1));
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    check(last_frame == exp, "R3 write frame bits", last_frame, exp);
    rd(3'd0, s);
    check(s == 32'd0, "R5 write request self-clears", 64'(s), 64'd0);
    rd(3'd4, s);
    check(s == rbefore, "R9 write leaves read data", 64'(s), 64'(rbefore));
    shadow[{p, r}]   = d;
    shadow_v[{p, r}] = 1;
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r);
    logic [31:0] s;
    logic [45:0] hexp;
    int f0;
    oe_bad = 0;
    wr(3'd1, {19'd0, p, 3'd0, r});
    f0 = frames;
    wr(3'd0, 32'h8);
    rd(3'd3, s);
    check(s == 32'd1, "R5 busy after read request", 64'(s), 64'd1);
    wait_idle();
    hexp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    check(frames == f0 + 1 && last_frame[63:18] == hexp, "R4 read header",
          64'(last_frame[63:18]), 64'(hexp));
    check(!oe_bad, "R4 line released in turnaround", 64'(oe_bad), 64'd0);
    rd(3'd4, s);
    check(s == {16'd0, expect_rd(p, r)}, "R4 read data", 64'(s), 64'(expect_rd(p, r)));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] s;
    int f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), s);
      check(s == 32'd0, "R1 register reset value", 64'(s), 64'd0);
    end
    check(!mdc && !mdio_oe, "R1 bus idle after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R2 / R10 field layout
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, s);
    check(s == 32'h0000_1F1F, "R2 address fields", 64'(s), 64'h1F1F);
    wr(3'd1, 32'h0000_0A05); rd(3'd1, s);
    check(s == 32'h0000_0A05, "R2 address pattern", 64'(s), 64'h0A05);
    wr(3'd2, 32'hDEAD_BEEF); rd(3'd2, s);
    check(s == 32'h0000_BEEF, "R10 write data width", 64'(s), 64'hBEEF);

    // R3 write sweep
    for (int i = 0; i < 16; i++)
      do_write(5'(i), 5'(31 - i), 16'(i * 16'h1111) ^ 16'h8421);

    // R4 read sweeps, includes read-after-write at (5,26)
    for (int r = 0; r < 32; r++) do_read(5'd5, 5'(r));
    for (int p = 0; p < 32; p++) do_read(5'(p), 5'd9);

    // R6 request while busy
    wr(3'd1, {19'd0, 5'd3, 3'd0, 5'd4});
    f0 = frames;
    wr(3'd0, 32'h8);
    repeat (20) @(negedge clk);
    wr(3'd1, {19'd0, 5'd17, 3'd0, 5'd18});
    wr(3'd0, 32'h4);
    wait_idle();
    repeat (200) @(negedge clk);
    check(frames == f0 + 1, "R6 busy request ignored", 64'(frames), 64'(f0 + 1));
    check(last_frame[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd4},
          "R6 running frame kept fields", 64'(last_frame[63:18]),
          64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd4}));
    rd(3'd4, s);
    check(s == {16'd0, expect_rd(5'd3, 5'd4)}, "R6 read result intact",
          64'(s), 64'(expect_rd(5'd3, 5'd4)));

    // R7 ambiguous control writes
    f0 = frames;
    wr(3'd0, 32'hC); rd(3'd3, s);
    check(s == 32'd0, "R7 both bits start nothing", 64'(s), 64'd0);
    wr(3'd0, 32'h0); rd(3'd3, s);
    check(s == 32'd0, "R7 no bits start nothing", 64'(s), 64'd0);
    repeat (300) @(negedge clk);
    check(frames == f0 && !mdc, "R7 no frame on ambiguous write", 64'(frames), 64'(f0));

    // R8 clocking and data timing
    check(!period_bad, "R8 MDC period", 64'(period_bad), 64'd0);
    check(!glitch_bad, "R8 MDIO stable while MDC high", 64'(glitch_bad), 64'd0);
    check(!mdc && !mdio_oe, "R8 bus idle after traffic", {62'd0, mdc, mdio_oe}, 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule